// File: doc/BRIEF.md
# Fixed-Coefficient Edge Symbol Permuter for GF(2^p) Message Streams

This block sits on a single edge of a stochastic nonbinary LDPC decoder graph, between a variable node and a check node. Each edge carries a nonzero field coefficient h taken from the parity-check matrix. Symbols heading toward the check node are multiplied by h. Symbols heading back toward the variable node are multiplied by h^-1. The multiplication is thereby moved off the check node, so the check node only has to XOR its inputs. Both directions take one p-bit symbol per clock.

The coefficient is fixed when the block is elaborated. It is supplied as an exponent of the primitive element alpha, and the field is fixed by its width and its reduction polynomial. Because h is constant, each direction is built as a constant multiplier, not as a generic two-operand multiplier. A parameter selects the form of that multiplier: an XOR matrix, or a lookup table of 2^p-1 entries with a separate bypass for the zero symbol. A second parameter selects whether each direction ends in an output register.

Top module: `gf_edge_permuter`

## Requirements
- R1: Symbols use polynomial form, where bit k holds the coefficient of x^k. The default field is GF(16) reduced by x^4+x+1. The forward output equals the forward input multiplied by alpha^EXP_H, where alpha is the element with value 2.
- R2: The backward output equals the backward input multiplied by alpha^-EXP_H.
- R3: Passing any symbol through the forward path and then through the backward path returns the original symbol.
- R4: An input symbol of 0 gives an output of 0 in both directions.
- R5: Over the 2^p-1 nonzero inputs, each direction produces only nonzero outputs, and no output value appears twice.
- R6: With OUT_REG=1, the outputs are registered and appear one clock after the input. A synchronous active-high reset clears both outputs to 0.
- R7: With OUT_REG=0, both outputs are combinational and follow the inputs within the same cycle.
- R8: The table form (IMPL=IMPL_TABLE) and the logic form (IMPL=IMPL_LOGIC) produce identical outputs for every input symbol.
- R9: EXP_H is taken modulo 2^p-1. For example, EXP_H=15 in GF(16) gives h=1, so both directions pass symbols through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| fwd_sym_i | input | W | Symbol travelling from the variable node toward the check node |
| fwd_sym_o | output | W | fwd_sym_i multiplied by h |
| bwd_sym_i | input | W | Symbol travelling from the check node toward the variable node |
| bwd_sym_o | output | W | bwd_sym_i multiplied by h^-1 |

## Verification
Both directions are swept over every symbol of the field. This sweep is run on four elaborations: the logic form, the table form, a combinational variant, and a variant whose exponent wraps to the identity. Comparing the logic and table forms symbol by symbol separates errors in the table contents from errors in the XOR matrix. The identity variant exposes mistakes in reducing the exponent. A round-trip pattern feeds each forward result back into the backward input, so a wrong inverse exponent shows up even when each direction is correct on its own. Sweeping all nonzero inputs and recording which outputs appear detects a missing zero bypass, and detects any collision that would break the permutation.

// File: rtl/gf_perm_pkg.sv
package gf_perm_pkg;

    localparam int MAX_W = 8;

    typedef enum logic [0:0] {
        IMPL_LOGIC = 1'b0,
        IMPL_TABLE = 1'b1
    } mul_impl_e;

    typedef logic [MAX_W-1:0] gf_word_t;

    // Multiply by alpha (x) once, reducing modulo the field polynomial.
    function automatic gf_word_t gf_xtime(gf_word_t a, int w, int poly);
        gf_word_t mask;
        gf_word_t r;
        mask = gf_word_t'((1 << w) - 1);
        r    = (a << 1) & mask;
        if (a[w-1]) r = r ^ (gf_word_t'(poly) & mask);
        return r;
    endfunction

    // Shift-and-add field multiplication, used only at elaboration time.
    function automatic gf_word_t gf_mul(gf_word_t a, gf_word_t b, int w, int poly);
        gf_word_t acc;
        gf_word_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < MAX_W; i++) begin
            if (i < w) begin
                if (b[i]) acc = acc ^ sh;
                sh = gf_xtime(sh, w, poly);
            end
        end
        return acc;
    endfunction

    function automatic int gf_norm_exp(int e, int w);
        int ord;
        ord = (1 << w) - 1;
        return ((e % ord) + ord) % ord;
    endfunction

    function automatic int gf_inv_exp(int e, int w);
        int ord;
        ord = (1 << w) - 1;
        return (ord - gf_norm_exp(e, w)) % ord;
    endfunction

    // alpha raised to a reduced exponent.
    function automatic gf_word_t gf_alpha_pow(int e, int w, int poly);
        gf_word_t r;
        int       n;
        r = gf_word_t'(1);
        n = gf_norm_exp(e, w);
        for (int k = 0; k < (1 << MAX_W); k++) begin
            if (k < n) r = gf_xtime(r, w, poly);
        end
        return r;
    endfunction

endpackage

// File: rtl/gf_cmul_logic.sv
module gf_cmul_logic #(
    parameter int W    = 4,
    parameter int POLY = 'h3,
    parameter int EXPN = 0
) (
    input  logic [W-1:0] sym_i,
    output logic [W-1:0] sym_o
);
    import gf_perm_pkg::*;

    localparam gf_word_t COEF = gf_alpha_pow(EXPN, W, POLY);

    logic [W-1:0] col [W];

    // Column j of the constant matrix is COEF * x^j.
    for (genvar j = 0; j < W; j++) begin : g_col
        localparam gf_word_t COL = gf_mul(gf_word_t'(1 << j), COEF, W, POLY);
        assign col[j] = sym_i[j] ? COL[W-1:0] : '0;
    end

    always_comb begin
        sym_o = '0;
        for (int j = 0; j < W; j++) sym_o = sym_o ^ col[j];
    end

endmodule

// File: rtl/gf_cmul_table.sv
module gf_cmul_table #(
    parameter int W    = 4,
    parameter int POLY = 'h3,
    parameter int EXPN = 0
) (
    input  logic [W-1:0] sym_i,
    output logic [W-1:0] sym_o
);
    import gf_perm_pkg::*;

    localparam int       ENTRIES = (1 << W) - 1;
    localparam gf_word_t COEF    = gf_alpha_pow(EXPN, W, POLY);

    logic [W-1:0] tbl [ENTRIES];
    logic [W-1:0] idx;

    // Entry k holds (k+1) * COEF; the zero symbol is not stored.
    for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
        localparam gf_word_t ENT = gf_mul(gf_word_t'(k + 1), COEF, W, POLY);
        assign tbl[k] = ENT[W-1:0];
    end

    assign idx = sym_i - 1'b1;

    always_comb begin
        if (sym_i == '0) sym_o = '0;
        else             sym_o = tbl[idx];
    end

endmodule

// File: rtl/gf_cmul_path.sv
module gf_cmul_path #(
    parameter int                     W       = 4,
    parameter int                     POLY    = 'h3,
    parameter int                     EXPN    = 0,
    parameter gf_perm_pkg::mul_impl_e IMPL    = gf_perm_pkg::IMPL_LOGIC,
    parameter bit                     OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sym_i,
    output logic [W-1:0] sym_o
);
    logic [W-1:0] prod;

    if (IMPL == gf_perm_pkg::IMPL_TABLE) begin : g_tab
        gf_cmul_table #(.W(W), .POLY(POLY), .EXPN(EXPN)) u_mul (
            .sym_i (sym_i),
            .sym_o (prod)
        );
    end else begin : g_log
        gf_cmul_logic #(.W(W), .POLY(POLY), .EXPN(EXPN)) u_mul (
            .sym_i (sym_i),
            .sym_o (prod)
        );
    end

    if (OUT_REG) begin : g_reg
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= prod;
        end
        assign sym_o = q;
    end else begin : g_cmb
        logic unused_clk;
        assign unused_clk = clk ^ rst;
        assign sym_o = prod;
    end

endmodule

// File: rtl/gf_edge_permuter.sv
module gf_edge_permuter #(
    parameter int                     W       = 4,
    parameter int                     POLY    = 'h3,
    parameter int                     EXP_H   = 7,
    parameter gf_perm_pkg::mul_impl_e IMPL    = gf_perm_pkg::IMPL_LOGIC,
    parameter bit                     OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] fwd_sym_i,
    output logic [W-1:0] fwd_sym_o,
    input  logic [W-1:0] bwd_sym_i,
    output logic [W-1:0] bwd_sym_o
);
    localparam int FWD_EXP = gf_perm_pkg::gf_norm_exp(EXP_H, W);
    localparam int BWD_EXP = gf_perm_pkg::gf_inv_exp(EXP_H, W);

    gf_cmul_path #(
        .W(W), .POLY(POLY), .EXPN(FWD_EXP), .IMPL(IMPL), .OUT_REG(OUT_REG)
    ) u_fwd (
        .clk   (clk),
        .rst   (rst),
        .sym_i (fwd_sym_i),
        .sym_o (fwd_sym_o)
    );

    gf_cmul_path #(
        .W(W), .POLY(POLY), .EXPN(BWD_EXP), .IMPL(IMPL), .OUT_REG(OUT_REG)
    ) u_bwd (
        .clk   (clk),
        .rst   (rst),
        .sym_i (bwd_sym_i),
        .sym_o (bwd_sym_o)
    );

endmodule

// File: rtl/gf_edge_permuter_chk.sv
module gf_edge_permuter_chk #(
    parameter int W       = 4,
    parameter int POLY    = 'h3,
    parameter int EXP_H   = 7,
    parameter bit OUT_REG = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] fwd_sym_i,
    input logic [W-1:0] fwd_sym_o,
    input logic [W-1:0] bwd_sym_i,
    input logic [W-1:0] bwd_sym_o
);
    import gf_perm_pkg::*;

    localparam gf_word_t HF = gf_alpha_pow(EXP_H, W, POLY);
    localparam gf_word_t HB = gf_alpha_pow(gf_inv_exp(EXP_H, W), W, POLY);

    function automatic logic [W-1:0] mul_f(logic [W-1:0] x);
        gf_word_t r;
        r = gf_mul(gf_word_t'(x), HF, W, POLY);
        return r[W-1:0];
    endfunction

    function automatic logic [W-1:0] mul_b(logic [W-1:0] x);
        gf_word_t r;
        r = gf_mul(gf_word_t'(x), HB, W, POLY);
        return r[W-1:0];
    endfunction

    if (OUT_REG) begin : g_seq
        // R6
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> (fwd_sym_o == '0 && bwd_sym_o == '0));

        // R4
        zero_fwd_chk: assert property (@(posedge clk) disable iff (rst)
            (fwd_sym_i == '0) |=> (fwd_sym_o == '0));

        // R4
        zero_bwd_chk: assert property (@(posedge clk) disable iff (rst)
            (bwd_sym_i == '0) |=> (bwd_sym_o == '0));

        // R5
        nonzero_fwd_chk: assert property (@(posedge clk) disable iff (rst)
            (fwd_sym_i != '0) |=> (fwd_sym_o != '0));

        // R1
        mul_fwd_chk: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (fwd_sym_o == mul_f($past(fwd_sym_i))));

        // R2
        mul_bwd_chk: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (bwd_sym_o == mul_b($past(bwd_sym_i))));
    end else begin : g_cmb
        // R7
        always @(negedge clk) begin
            if (!rst) begin
                comb_fwd_chk: assert (fwd_sym_o == mul_f(fwd_sym_i));
                comb_bwd_chk: assert (bwd_sym_o == mul_b(bwd_sym_i));
            end
        end
    end

endmodule

bind gf_edge_permuter gf_edge_permuter_chk #(
    .W(W), .POLY(POLY), .EXP_H(EXP_H), .OUT_REG(OUT_REG)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fwd_sym_i (fwd_sym_i),
    .fwd_sym_o (fwd_sym_o),
    .bwd_sym_i (bwd_sym_i),
    .bwd_sym_o (bwd_sym_o)
);

// File: tb/tb_gf_edge_permuter.sv
`timescale 1ns/1ps
module tb_gf_edge_permuter;

    localparam int W = 4;
    localparam int N = 1 << W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0] f_in, b_in;
    logic [W-1:0] f_out, b_out, tf_out, tb_out, cf_out, cb_out, if_out, ib_out;

    int nvec = 0;
    int nfail = 0;

    gf_edge_permuter #(.EXP_H(7), .IMPL(gf_perm_pkg::IMPL_LOGIC), .OUT_REG(1'b1)) dut (
        .clk(clk), .rst(rst), .fwd_sym_i(f_in), .fwd_sym_o(f_out),
        .bwd_sym_i(b_in), .bwd_sym_o(b_out));

    gf_edge_permuter #(.EXP_H(7), .IMPL(gf_perm_pkg::IMPL_TABLE), .OUT_REG(1'b1)) dut_tab (
        .clk(clk), .rst(rst), .fwd_sym_i(f_in), .fwd_sym_o(tf_out),
        .bwd_sym_i(b_in), .bwd_sym_o(tb_out));

    gf_edge_permuter #(.EXP_H(7), .IMPL(gf_perm_pkg::IMPL_LOGIC), .OUT_REG(1'b0)) dut_cmb (
        .clk(clk), .rst(rst), .fwd_sym_i(f_in), .fwd_sym_o(cf_out),
        .bwd_sym_i(b_in), .bwd_sym_o(cb_out));

    gf_edge_permuter #(.EXP_H(15), .IMPL(gf_perm_pkg::IMPL_TABLE), .OUT_REG(1'b1)) dut_id (
        .clk(clk), .rst(rst), .fwd_sym_i(f_in), .fwd_sym_o(if_out),
        .bwd_sym_i(b_in), .bwd_sym_o(ib_out));

    // Reference: carry-less product, then reduction by x^4+x+1 (0x13).
    function automatic logic [W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
        logic [7:0] p;
        p = '0;
        for (int i = 0; i < W; i++) if (b[i]) p = p ^ (8'(a) << i);
        for (int k = 7; k >= W; k--) if (p[k]) p = p ^ (8'h13 << (k - W));
        return p[W-1:0];
    endfunction

    function automatic logic [W-1:0] ref_pow(int e);
        logic [W-1:0] r;
        r = 4'd1;
        for (int k = 0; k < e; k++) r = ref_mul(r, 4'd2);
        return r;
    endfunction

    logic [W-1:0] h_f, h_b;

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at negedge, registered result visible at the following negedge.
    task automatic step(logic [W-1:0] f, logic [W-1:0] b);
        f_in = f;
        b_in = b;
        #1;
        check("R7", "comb fwd", cf_out, ref_mul(f, h_f));
        check("R7", "comb bwd", cb_out, ref_mul(b, h_b));
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        f_in = 4'h9; b_in = 4'h6;
        repeat (3) @(negedge clk);
        // R6: registered outputs held at zero during reset
        check("R6", "reset fwd", f_out, '0);
        check("R6", "reset bwd", b_out, '0);
        check("R6", "reset table fwd", tf_out, '0);
        rst = 1'b0;
    endtask

    task automatic t_sweep();
        for (int x = 0; x < N; x++) begin
            step(4'(x), 4'(N - 1 - x));
            check("R1", "fwd", f_out, ref_mul(4'(x), h_f));
            check("R2", "bwd", b_out, ref_mul(4'(N - 1 - x), h_b));
            check("R8", "table fwd", tf_out, f_out);
            check("R8", "table bwd", tb_out, b_out);
            check("R9", "identity fwd", if_out, 4'(x));
            check("R9", "identity bwd", ib_out, 4'(N - 1 - x));
        end
    endtask

    task automatic t_zero();
        step(4'h0, 4'h0);
        check("R4", "zero fwd", f_out, '0);
        check("R4", "zero bwd", b_out, '0);
        check("R4", "zero table fwd", tf_out, '0);
        check("R4", "zero table bwd", tb_out, '0);
    endtask

    task automatic t_perm();
        logic [N-1:0] seen_f, seen_b;
        seen_f = '0;
        seen_b = '0;
        for (int x = 1; x < N; x++) begin
            step(4'(x), 4'(x));
            check("R5", "fwd nonzero", 4'(f_out != 0), 4'd1);
            check("R5", "fwd unique", 4'(seen_f[f_out]), 4'd0);
            check("R5", "bwd unique", 4'(seen_b[b_out]), 4'd0);
            seen_f[f_out] = 1'b1;
            seen_b[b_out] = 1'b1;
        end
    endtask

    task automatic t_round();
        for (int x = 0; x < N; x++) begin
            logic [W-1:0] y;
            step(4'(x), 4'h0);
            y = f_out;
            step(4'h0, y);
            check("R3", "round trip logic", b_out, 4'(x));
            check("R3", "round trip table", tb_out, ref_mul(ref_mul(4'(x), h_f), h_b));
        end
    endtask

    task automatic t_latency();
        // R6: one-cycle latency, output holds previous value before the edge
        step(4'h1, 4'h1);
        f_in = 4'h2;
        #1;
        check("R6", "latency hold", f_out, h_f);
        @(negedge clk);
        check("R6", "latency update", f_out, ref_mul(4'h2, h_f));
    endtask

    initial begin
        h_f = ref_pow(7);
        h_b = ref_pow(8);
        check("R1", "coefficient", h_f, 4'hB);
        check("R2", "inverse coefficient", ref_mul(h_f, h_b), 4'h1);
        @(negedge clk);
        t_reset();
        t_sweep();
        t_zero();
        t_perm();
        t_round();
        t_latency();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #200000;
        nvec++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule